// File: doc/BRIEF.md
# DMA Page Register Bank and Physical Address Generator

This block keeps, for each of four DMA channels, a low page byte and (when the `HI_EN` parameter is set) a high page byte. Software reaches them through a small port window addressed by a 3-bit offset. Only four of the eight offsets are backed by storage, and they map to channels in a scrambled order. A separate select input switches between the low and the high window. Both windows use the same offsets.

For each transfer the channel logic presents a request on a valid/ready stream. The request carries the channel number, the channel's programmed base address, the position within the block, the block length and the direction flag. The block turns this into a physical address that joins the channel's page bytes with a 16-bit offset. The offset counts upward in increment mode. In decrement mode it is placed below the base so that the block is delivered in reverse. A controller-wide pin selects 16-bit operation, in which the base is doubled. The result leaves on a second valid/ready stream through a one-entry output register. A request is accepted only when that register is empty or is being drained in the same cycle, so back-pressure on the output stalls the input by exactly one slot.

Top module: `dma_page_addr_gen`

## Requirements
- R1: Port offsets map to channels as follows: offset 7 selects channel 0, offset 3 selects channel 1, offset 1 selects channel 2 and offset 2 selects channel 3. A byte written at an offset is read back at that offset and is the page used for transfers on the mapped channel.
- R2: Offsets 0, 4, 5 and 6 hold no register. A write there changes nothing, and a read there returns all ones (0xFF).
- R3: With `pg_hi_sel` = 1 the same offsets reach a separate high page bank. Writes in one window never alter the other window.
- R4: `addr_out` is {high page bits [6:0], low page [7:0], offset [15:0]}, 31 bits wide. Bit 7 of the high page is not used in the address.
- R5: With `xfer_dec` = 0 the offset is (start + position) modulo 65536.
- R6: With `xfer_dec` = 1 the offset is (start − position − length) modulo 65536, and `addr_rev` is 1 so that the bytes are delivered in reverse order. `addr_rev` is 0 in increment mode.
- R7: With `wide_mode` = 1 the start is the base shifted left one bit and truncated to 16 bits. With `wide_mode` = 0 the start is the base itself.
- R8: `addr_valid` rises in the cycle after a request is accepted. While `addr_valid` = 1 and `addr_ready` = 0, `addr_out` and `addr_rev` hold their values.
- R9: `xfer_ready` is 1 exactly when the output register is empty or is being drained (`addr_ready` = 1) in that cycle.
- R10: When a page write and an accepted request for the same channel fall in the same cycle, the request uses the page value from before the write. The next request uses the new value.
- R11: After reset all page bytes read 0 and `addr_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wide_mode | input | 1 | 1: 16-bit controller, the base is doubled |
| pg_hi_sel | input | 1 | 0: low page window, 1: high page window |
| pg_off | input | 3 | Port offset inside the window |
| pg_wr | input | 1 | Write strobe for the page window |
| pg_wdata | input | 8 | Write data |
| pg_rdata | output | 8 | Read data at `pg_off` (combinational) |
| xfer_valid | input | 1 | Request valid |
| xfer_ready | output | 1 | Request accepted when high together with valid |
| xfer_chan | input | 2 | Channel number |
| xfer_base | input | 16 | Programmed base address of the channel |
| xfer_pos | input | 16 | Position inside the block |
| xfer_len | input | 16 | Block length |
| xfer_dec | input | 1 | 1: decrement addressing |
| addr_valid | output | 1 | Address result valid |
| addr_ready | input | 1 | Consumer takes the result |
| addr_out | output | 31 | Physical address |
| addr_rev | output | 1 | 1: deliver the block in reverse byte order |

## Verification
The risky overlap is a page write landing in the same clock edge at which a request for that same channel is accepted. The bench raises `pg_wr` and `xfer_valid` together while the output register is empty. It expects the old page in that result and the new page in the request that follows. The second overlap is an output drain and a new acceptance in one cycle. Back-pressure bursts are used to show that a result is neither lost nor duplicated and stays frozen while stalled.

// File: rtl/dma_pg_pkg.sv
package dma_pg_pkg;

  localparam int NUM_CH  = 4;
  localparam int CH_W    = $clog2(NUM_CH);
  localparam int PORT_W  = 3;

  typedef struct packed {
    logic            hit;
    logic [CH_W-1:0] ch;
  } pg_decode_t;

  // Sparse port offset to channel mapping; unlisted offsets are holes.
  function automatic pg_decode_t pg_decode(input logic [PORT_W-1:0] ofs);
    pg_decode_t d;
    d.hit = 1'b1;
    d.ch  = '0;
    case (ofs)
      3'd7:    d.ch = 2'd0;
      3'd3:    d.ch = 2'd1;
      3'd1:    d.ch = 2'd2;
      3'd2:    d.ch = 2'd3;
      default: d.hit = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/dma_pg_slots.sv
module dma_pg_slots
  import dma_pg_pkg::*;
#(
  parameter int W   = 8,
  parameter int RBW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CH_W-1:0] wr_ch,
  input  logic [W-1:0]    wr_data,
  input  logic [CH_W-1:0] rd_ch_a,
  output logic [W-1:0]    rd_a,
  input  logic [CH_W-1:0] rd_ch_b,
  output logic [RBW-1:0]  rd_b
);

  logic [W-1:0] slot_q [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[c] <= '0;
      else if (wr_en && (wr_ch == c))
        slot_q[c] <= wr_data;
    end
  end

  assign rd_a = slot_q[rd_ch_a];
  assign rd_b = slot_q[rd_ch_b][RBW-1:0];

endmodule

// File: rtl/dma_pg_ofs_calc.sv
module dma_pg_ofs_calc #(
  parameter int OFS_W = 16
) (
  input  logic [OFS_W-1:0] base,
  input  logic [OFS_W-1:0] pos,
  input  logic [OFS_W-1:0] len,
  input  logic             dec,
  input  logic             wide,
  output logic [OFS_W-1:0] ofs
);

  logic [OFS_W-1:0] start;

  always_comb begin
    start = wide ? {base[OFS_W-2:0], 1'b0} : base;
    if (dec)
      ofs = start - pos - len;
    else
      ofs = start + pos;
  end

endmodule

// File: rtl/dma_pg_out_reg.sv
module dma_pg_out_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid)
        out_data <= in_data;
    end
  end

endmodule

// File: rtl/dma_page_addr_gen.sv
module dma_page_addr_gen
  import dma_pg_pkg::*;
#(
  parameter int  OFS_W      = 16,
  parameter int  PAGE_W     = 8,
  parameter int  HPAGE_BITS = 7,
  parameter bit  HI_EN      = 1'b1,
  localparam int ADDR_W     = HPAGE_BITS + PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_mode,
  input  logic              pg_hi_sel,
  input  logic [PORT_W-1:0] pg_off,
  input  logic              pg_wr,
  input  logic [PAGE_W-1:0] pg_wdata,
  output logic [PAGE_W-1:0] pg_rdata,
  input  logic              xfer_valid,
  output logic              xfer_ready,
  input  logic [CH_W-1:0]   xfer_chan,
  input  logic [OFS_W-1:0]  xfer_base,
  input  logic [OFS_W-1:0]  xfer_pos,
  input  logic [OFS_W-1:0]  xfer_len,
  input  logic              xfer_dec,
  output logic              addr_valid,
  input  logic              addr_ready,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_rev
);

  localparam int PKT_W = ADDR_W + 1;

  pg_decode_t            dec;
  logic                  hi_window_ok;
  logic                  lo_wr, hi_wr;
  logic [PAGE_W-1:0]     lo_rd, hi_rd;
  logic [PAGE_W-1:0]     lo_page;
  logic [HPAGE_BITS-1:0] hi_page;
  logic [OFS_W-1:0]      ofs;
  logic [PKT_W-1:0]      pkt_in, pkt_out;

  assign dec          = pg_decode(pg_off);
  assign hi_window_ok = HI_EN;
  assign lo_wr        = pg_wr && dec.hit && !pg_hi_sel;
  assign hi_wr        = pg_wr && dec.hit && pg_hi_sel && hi_window_ok;

  dma_pg_slots #(.W(PAGE_W), .RBW(PAGE_W)) u_lo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (lo_wr),
    .wr_ch   (dec.ch),
    .wr_data (pg_wdata),
    .rd_ch_a (dec.ch),
    .rd_a    (lo_rd),
    .rd_ch_b (xfer_chan),
    .rd_b    (lo_page)
  );

  if (HI_EN) begin : g_hi
    dma_pg_slots #(.W(PAGE_W), .RBW(HPAGE_BITS)) u_hi (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (hi_wr),
      .wr_ch   (dec.ch),
      .wr_data (pg_wdata),
      .rd_ch_a (dec.ch),
      .rd_a    (hi_rd),
      .rd_ch_b (xfer_chan),
      .rd_b    (hi_page)
    );
  end else begin : g_no_hi
    assign hi_rd   = '1;
    assign hi_page = '0;
  end

  always_comb begin
    if (!dec.hit)
      pg_rdata = '1;
    else if (pg_hi_sel)
      pg_rdata = hi_rd;
    else
      pg_rdata = lo_rd;
  end

  dma_pg_ofs_calc #(.OFS_W(OFS_W)) u_ofs (
    .base (xfer_base),
    .pos  (xfer_pos),
    .len  (xfer_len),
    .dec  (xfer_dec),
    .wide (wide_mode),
    .ofs  (ofs)
  );

  assign pkt_in = {xfer_dec, hi_page, lo_page, ofs};

  dma_pg_out_reg #(.W(PKT_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (xfer_valid),
    .in_ready  (xfer_ready),
    .in_data   (pkt_in),
    .out_valid (addr_valid),
    .out_ready (addr_ready),
    .out_data  (pkt_out)
  );

  assign addr_rev = pkt_out[PKT_W-1];
  assign addr_out = pkt_out[ADDR_W-1:0];

endmodule

// File: rtl/dma_pg_checker.sv
module dma_pg_checker #(
  parameter int ADDR_W = 31,
  parameter int PAGE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pg_hi_sel,
  input logic [2:0]        pg_off,
  input logic [PAGE_W-1:0] pg_rdata,
  input logic              xfer_valid,
  input logic              xfer_ready,
  input logic              xfer_dec,
  input logic              addr_valid,
  input logic              addr_ready,
  input logic [ADDR_W-1:0] addr_out,
  input logic              addr_rev
);

  logic hole;
  assign hole = (pg_off == 3'd0) || (pg_off == 3'd4) ||
                (pg_off == 3'd5) || (pg_off == 3'd6);

  a_r8_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready) |=> addr_valid);

  a_r8_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr_out) && $stable(addr_rev)));

  a_r9_no_accept_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready) |-> !xfer_ready);

  a_r9_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |-> xfer_ready);

  a_r6_rev_follows_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready) |=> (addr_rev == $past(xfer_dec)));

  a_r2_hole_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (hole && !pg_hi_sel) |-> (&pg_rdata));

  a_r11_empty_out_of_reset: assert property (@(posedge clk)
    !rst_n |=> !addr_valid);

endmodule

bind dma_page_addr_gen dma_pg_checker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pg_hi_sel  (pg_hi_sel),
  .pg_off     (pg_off),
  .pg_rdata   (pg_rdata),
  .xfer_valid (xfer_valid),
  .xfer_ready (xfer_ready),
  .xfer_dec   (xfer_dec),
  .addr_valid (addr_valid),
  .addr_ready (addr_ready),
  .addr_out   (addr_out),
  .addr_rev   (addr_rev)
);

// File: tb/test_dma_page_addr_gen.sv
`timescale 1ns/1ps
module test_dma_page_addr_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_mode = 1'b0;
  logic        pg_hi_sel = 1'b0;
  logic [2:0]  pg_off = '0;
  logic        pg_wr = 1'b0;
  logic [7:0]  pg_wdata = '0;
  logic [7:0]  pg_rdata;
  logic        xfer_valid = 1'b0;
  logic        xfer_ready;
  logic [1:0]  xfer_chan = '0;
  logic [15:0] xfer_base = '0, xfer_pos = '0, xfer_len = '0;
  logic        xfer_dec = 1'b0;
  logic        addr_valid;
  logic        addr_ready = 1'b1;
  logic [30:0] addr_out;
  logic        addr_rev;

  always #10 clk = ~clk;

  dma_page_addr_gen i_dma_page_addr_gen (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
    .pg_hi_sel(pg_hi_sel), .pg_off(pg_off), .pg_wr(pg_wr),
    .pg_wdata(pg_wdata), .pg_rdata(pg_rdata),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_chan(xfer_chan),
    .xfer_base(xfer_base), .xfer_pos(xfer_pos), .xfer_len(xfer_len),
    .xfer_dec(xfer_dec), .addr_valid(addr_valid), .addr_ready(addr_ready),
    .addr_out(addr_out), .addr_rev(addr_rev)
  );

  typedef struct {
    logic [30:0] a;
    logic        r;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_bad = 0;
  bit   done  = 1'b0;
  logic [7:0] lo_m [4];
  logic [7:0] hi_m [4];

  function automatic int chan_of(input int ofs);
    case (ofs)
      7: return 0;
      3: return 1;
      1: return 2;
      2: return 3;
      default: return -1;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pg_write(input bit hi, input int ofs, input logic [7:0] v);
    int c;
    @(negedge clk);
    pg_hi_sel = hi; pg_off = 3'(ofs); pg_wdata = v; pg_wr = 1'b1;
    @(negedge clk);
    pg_wr = 1'b0;
    c = chan_of(ofs);
    if (c >= 0) begin
      if (hi) hi_m[c] = v; else lo_m[c] = v;
    end
  endtask

  task automatic pg_read(input bit hi, input int ofs, input logic [7:0] e, input string tag);
    @(negedge clk);
    pg_hi_sel = hi; pg_off = 3'(ofs);
    #1;
    check(pg_rdata === e, tag, 32'(pg_rdata), 32'(e));
  endtask

  function automatic logic [30:0] model(input int ch, input logic [15:0] b,
      input logic [15:0] p, input logic [15:0] l, input bit d, input bit w);
    logic [15:0] s, o;
    s = w ? {b[14:0], 1'b0} : b;
    o = d ? (s - p - l) : (s + p);
    return {hi_m[ch][6:0], lo_m[ch], o};
  endfunction

  task automatic send(input int ch, input logic [15:0] b, input logic [15:0] p,
      input logic [15:0] l, input bit d, input string tag);
    exp_t e;
    @(negedge clk);
    xfer_valid = 1'b1; xfer_chan = 2'(ch); xfer_base = b; xfer_pos = p;
    xfer_len = l; xfer_dec = d;
    #1;
    while (!xfer_ready) begin
      @(negedge clk);
      #1;
    end
    e.a = model(ch, b, p, l, d, wide_mode); e.r = d; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    xfer_valid = 1'b0;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    #2;
    if (rst_n && addr_valid && addr_ready) begin
      exp_t e;
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected result", 32'(addr_out), 32'h0);
      end else begin
        e = exp_q.pop_front();
        check(addr_out === e.a, e.tag, 32'(addr_out), 32'(e.a));
        check(addr_rev === e.r, {e.tag, " R6 rev"}, 32'(addr_rev), 32'(e.r));
      end
    end
  end

  task automatic drain;
    for (int i = 0; i < 50 && exp_q.size() != 0; i++) @(negedge clk);
    check(exp_q.size() == 0, "R8 drain", 32'(exp_q.size()), 32'h0);
  endtask

  initial begin : watchdog
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [30:0] held;
    for (int c = 0; c < 4; c++) begin lo_m[c] = '0; hi_m[c] = '0; end
    repeat (3) @(negedge clk);
    #1;
    check(addr_valid === 1'b0, "R11 addr_valid in reset", 32'(addr_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(addr_valid === 1'b0, "R11 addr_valid after reset", 32'(addr_valid), 32'h0);
    foreach (lo_m[c]) begin end
    pg_read(0, 7, 8'h00, "R11 low page reset");
    pg_read(0, 2, 8'h00, "R11 low page reset");
    pg_read(1, 3, 8'h00, "R11 high page reset");

    // R1: mapping
    pg_write(0, 1, 8'h21); pg_write(0, 2, 8'h32);
    pg_write(0, 3, 8'h13); pg_write(0, 7, 8'h07);
    pg_read(0, 1, 8'h21, "R1 readback off1");
    pg_read(0, 7, 8'h07, "R1 readback off7");
    // R2: holes
    pg_write(0, 0, 8'h5A); pg_write(0, 4, 8'h5A);
    pg_write(0, 5, 8'h5A); pg_write(0, 6, 8'h5A);
    for (int o = 0; o < 8; o++) begin
      if (chan_of(o) < 0) pg_read(0, o, 8'hFF, "R2 hole reads FF");
      else pg_read(0, o, lo_m[chan_of(o)], "R2 mapped unchanged after hole writes");
    end
    // R3: high window
    pg_write(1, 1, 8'hC5); pg_write(1, 2, 8'h46);
    pg_write(1, 3, 8'h7F); pg_write(1, 7, 8'hFF);
    pg_read(1, 2, 8'h46, "R3 high readback");
    pg_read(1, 7, 8'hFF, "R3 high readback");
    pg_read(0, 2, 8'h32, "R3 low untouched by high write");
    pg_read(0, 3, 8'h13, "R3 low untouched by high write");
    pg_write(0, 3, 8'h99);
    pg_read(1, 3, 8'h7F, "R3 high untouched by low write");

    // R1/R4/R5: increment addressing on each channel
    send(0, 16'h1000, 16'h0004, 16'h0010, 0, "R1 R4 R5 ch0 inc");
    send(1, 16'h2345, 16'h0000, 16'h0001, 0, "R1 R4 R5 ch1 inc");
    send(2, 16'hABCD, 16'h0100, 16'h0200, 0, "R1 R4 ch2 inc");
    send(3, 16'hFFF0, 16'h0020, 16'h0040, 0, "R5 ch3 wrap");
    // R6: decrement
    send(2, 16'h8000, 16'h0010, 16'h0020, 1, "R6 dec");
    send(1, 16'h0004, 16'h0002, 16'h0008, 1, "R6 dec wrap");
    // R7: 16-bit mode
    wide_mode = 1'b1;
    send(0, 16'h8001, 16'h0000, 16'h0001, 0, "R7 wide truncate");
    send(3, 16'h1234, 16'h0010, 16'h0004, 1, "R7 wide dec");
    wide_mode = 1'b0;
    drain();

    // R8/R9: back-pressure
    @(negedge clk);
    addr_ready = 1'b0;
    send(2, 16'h0100, 16'h0001, 16'h0001, 0, "R8 stalled item");
    #1;
    check(addr_valid === 1'b1, "R8 valid after accept", 32'(addr_valid), 32'h1);
    held = addr_out;
    xfer_valid = 1'b1; xfer_chan = 2'd0; xfer_base = 16'h7777;
    xfer_pos = '0; xfer_len = '0; xfer_dec = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #1;
      check(xfer_ready === 1'b0, "R9 not ready when full", 32'(xfer_ready), 32'h0);
      check(addr_out === held, "R8 held under stall", 32'(addr_out), 32'(held));
    end
    xfer_valid = 1'b0;
    @(negedge clk);
    addr_ready = 1'b1;
    #1;
    check(xfer_ready === 1'b1, "R9 ready while draining", 32'(xfer_ready), 32'h1);
    drain();
    // Back-to-back with alternating ready
    fork
      begin
        send(3, 16'h4000, 16'h0001, 16'h0002, 0, "R9 b2b 1");
        send(3, 16'h4000, 16'h0002, 16'h0002, 1, "R9 b2b 2");
        send(0, 16'h0010, 16'h0003, 16'h0002, 0, "R9 b2b 3");
      end
      begin
        for (int k = 0; k < 12; k++) begin
          @(negedge clk);
          addr_ready = k[0];
        end
        addr_ready = 1'b1;
      end
    join
    drain();

    // R10: page write and accepted request in the same cycle
    @(negedge clk);
    begin
      exp_t e;
      pg_hi_sel = 1'b0; pg_off = 3'd1; pg_wdata = 8'hE1; pg_wr = 1'b1;
      xfer_valid = 1'b1; xfer_chan = 2'd2; xfer_base = 16'h0200;
      xfer_pos = 16'h0003; xfer_len = 16'h0001; xfer_dec = 1'b0;
      #1;
      check(xfer_ready === 1'b1, "R10 ready for collision", 32'(xfer_ready), 32'h1);
      e.a = model(2, 16'h0200, 16'h0003, 16'h0001, 0, 0); e.r = 1'b0;
      e.tag = "R10 old page used";
      exp_q.push_back(e);
      @(negedge clk);
      pg_wr = 1'b0; xfer_valid = 1'b0;
      lo_m[2] = 8'hE1;
    end
    send(2, 16'h0200, 16'h0003, 16'h0001, 0, "R10 new page next");
    drain();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule